// File: doc/BRIEF.md
# Two-Level Parallel Wide Word Comparator

This block decides the magnitude relation between two 24-bit unsigned words. It is built from six identical 4-bit cascadable comparator slices. A serial chain of such slices would need six slice delays for 24 bits. Here they form a two-level tree, so every result passes through exactly two slices.

The first level has five slices. One slice compares the four least significant bits. Its cascade inputs are tied to "equal", so it yields a clean greater, less or equal result. The other four slices each cover a 5-bit group (bits 4–8, 9–13, 14–18 and 19–23). In each of these, the lowest bit of the group enters through the cascade inputs. A's bit drives the greater-in input, B's bit drives the less-in input, and equal-in is held low.

The greater and less outputs of a 5-bit group do not form a result on their own. For an equal group they are both high or both low. They become a valid comparison once they feed the data inputs of another slice. The second-level slice therefore takes the four groups' greater outputs as its A word and their less outputs as its B word, with the bits 19–23 group in the top position. Its cascade inputs come from the low 4-bit slice. The three flags of this second-level slice are the block's result. The result is purely combinational, with no clock and no state.

Top module: `wide_word_cmp`

## Requirements
- R1: `aGtB` is high exactly when `opA` is greater than `opB`, both read as unsigned 24-bit numbers.
- R2: `aLtB` is high exactly when `opA` is less than `opB`, both read as unsigned 24-bit numbers.
- R3: `aEqB` is high exactly when all 24 bits of `opA` and `opB` match.
- R4: For every pair of input words, exactly one of `aGtB`, `aLtB` and `aEqB` is high.
- R5: When the two words differ in a single bit position, the flags follow the value of that bit in `opA`: 1 gives greater, 0 gives less. This holds at every position 0 through 23, including the bit that enters a group through the cascade inputs.
- R6: When the two words differ in several bits, the most significant differing bit alone decides the result. All-ones against all-zeros gives greater, and the reverse gives less.
- R7: The flags are a combinational function of the present inputs. A new input pair is fully reflected at the outputs within the same clock period that applies it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 24 | First unsigned operand |
| opB | input | 24 | Second unsigned operand |
| aGtB | output | 1 | High when opA > opB |
| aLtB | output | 1 | High when opA < opB |
| aEqB | output | 1 | High when opA == opB |

## Verification
Every result is due in the same clock period as its stimulus, because the block holds no state. The bench therefore applies a new pair on each rising edge and compares all three flags against its own relational model on the following falling edge. By that point the two slice levels have settled, and the next pair has not yet been applied. Directed single-bit and multi-bit patterns target the group boundaries, where the cascade inputs carry a data bit, and random pairs fill in the rest.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;

  // Three-way outcome of one comparator slice, also used for its cascade inputs
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmpFlags;

  localparam cmpFlags CAS_TIE_EQ = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

endpackage

// File: rtl/wcmp_slice.sv
module wcmp_slice
  import wcmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  cmpFlags            casIn,
  output cmpFlags            res
);

  // A decision on the data bits wins; on a tie the cascade inputs are resolved.
  // eq-in high gives equal; otherwise each outward flag is high unless the
  // opposing cascade flag is high. Both-low in gives both-high out, and
  // both-high in gives all-low out.
  always_comb begin
    if (a > b) begin
      res = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
    end else if (a < b) begin
      res = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
    end else begin
      res.eq = casIn.eq;
      res.gt = !casIn.eq && !casIn.lt;
      res.lt = !casIn.eq && !casIn.gt;
    end
  end

endmodule

// File: rtl/wcmp_level1.sv
module wcmp_level1
  import wcmp_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int NUM_WIDE = 4,
  localparam int GRP_W   = SLICE_W + 1,
  localparam int WORD_W  = SLICE_W + NUM_WIDE * GRP_W
) (
  input  logic [WORD_W-1:0]   opA,
  input  logic [WORD_W-1:0]   opB,
  output cmpFlags             lowRes,
  output logic [NUM_WIDE-1:0] grpGt,
  output logic [NUM_WIDE-1:0] grpLt
);

  // Least significant slice with the cascade tie for a clean 3-way result
  wcmp_slice #(.SLICE_W(SLICE_W)) u_lowSlice (
    .a     (opA[SLICE_W-1:0]),
    .b     (opB[SLICE_W-1:0]),
    .casIn (CAS_TIE_EQ),
    .res   (lowRes)
  );

  // Equal flags of the wide groups carry no meaning in 5-bit mode
  logic [NUM_WIDE-1:0] eqUnused;

  for (genvar g = 0; g < NUM_WIDE; g++) begin : gWide
    localparam int BASE = SLICE_W + g * GRP_W;
    cmpFlags casGrp;
    cmpFlags grpRes;

    // Group LSB rides in on the cascade inputs; eq-in held low
    assign casGrp = '{gt: opA[BASE], lt: opB[BASE], eq: 1'b0};

    wcmp_slice #(.SLICE_W(SLICE_W)) u_wideSlice (
      .a     (opA[BASE+1 +: SLICE_W]),
      .b     (opB[BASE+1 +: SLICE_W]),
      .casIn (casGrp),
      .res   (grpRes)
    );

    assign grpGt[g]    = grpRes.gt;
    assign grpLt[g]    = grpRes.lt;
    assign eqUnused[g] = grpRes.eq;
  end

endmodule

// File: rtl/wide_word_cmp.sv
module wide_word_cmp
  import wcmp_pkg::*;
#(
  parameter int SLICE_W  = 4,
  localparam int NUM_WIDE = SLICE_W,
  localparam int WORD_W   = SLICE_W + NUM_WIDE * (SLICE_W + 1)
) (
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              aGtB,
  output logic              aLtB,
  output logic              aEqB
);

  cmpFlags             lowRes;
  cmpFlags             finalRes;
  logic [NUM_WIDE-1:0] grpGt;
  logic [NUM_WIDE-1:0] grpLt;

  wcmp_level1 #(.SLICE_W(SLICE_W), .NUM_WIDE(NUM_WIDE)) u_level1 (
    .opA    (opA),
    .opB    (opB),
    .lowRes (lowRes),
    .grpGt  (grpGt),
    .grpLt  (grpLt)
  );

  // Second level: group greater flags form A, group less flags form B
  wcmp_slice #(.SLICE_W(SLICE_W)) u_finalSlice (
    .a     (grpGt),
    .b     (grpLt),
    .casIn (lowRes),
    .res   (finalRes)
  );

  assign aGtB = finalRes.gt;
  assign aLtB = finalRes.lt;
  assign aEqB = finalRes.eq;

endmodule

// File: rtl/wide_word_cmp_chk.sv
module wide_word_cmp_chk #(
  parameter int WORD_W = 24
) (
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              aGtB,
  input logic              aLtB,
  input logic              aEqB
);

  always_comb begin
    if (!$isunknown({opA, opB, aGtB, aLtB, aEqB})) begin
      // R1
      gt_matches_chk: assert (aGtB == (opA > opB));
      // R2
      lt_matches_chk: assert (aLtB == (opA < opB));
      // R3
      eq_matches_chk: assert (aEqB == (opA == opB));
      // R4
      one_flag_chk: assert ($onehot({aGtB, aLtB, aEqB}));
    end
  end

endmodule

bind wide_word_cmp wide_word_cmp_chk #(.WORD_W(WORD_W)) u_chk (
  .opA  (opA),
  .opB  (opB),
  .aGtB (aGtB),
  .aLtB (aLtB),
  .aEqB (aEqB)
);

// File: tb/wide_word_cmp_bench.sv
module wide_word_cmp_bench;

  localparam int W = 24;
  localparam int NUM_RANDOM = 3000;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         aGtB, aLtB, aEqB;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wide_word_cmp u_wide_word_cmp (
    .opA  (opA),
    .opB  (opB),
    .aGtB (aGtB),
    .aLtB (aLtB),
    .aEqB (aEqB)
  );

  // Behavioural reference and comparison; called at the falling edge
  task automatic compareNow(input string tag);
    logic [2:0] expv;
    logic [2:0] actv;
    longint unsigned ua, ub;
    ua = longint'(opA);
    ub = longint'(opB);
    expv = {ua > ub, ua < ub, ua == ub};
    actv = {aGtB, aLtB, aEqB};
    nChecks++;
    if (actv !== expv) begin
      nFails++;
      $display("FAIL %s: a=%h b=%h actual gt/lt/eq=%b expected %b",
               tag, opA, opB, actv, expv);
    end
  endtask

  // R7: apply on a rising edge, result due before the falling edge of that period
  task automatic applyPair(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string tag);
    @(posedge clk);
    opA <= a;
    opB <= b;
    @(negedge clk);
    compareNow(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // Reset state: zero operands must read as equal (R3, R4)
    @(negedge clk);
    compareNow("R3 reset zeros");
    rst <= 1'b0;

    // R3: equal words of several shapes
    applyPair(24'hFFFFFF, 24'hFFFFFF, "R3 equal ones");
    applyPair(24'hA5C3E1, 24'hA5C3E1, "R3 equal mixed");
    applyPair(24'h000010, 24'h000010, "R3 equal group LSB");

    // R5: single-bit differences at every position, both directions
    for (int p = 0; p < W; p++) begin
      applyPair(W'(1) << p, '0, "R5 single bit A high");
      applyPair('0, W'(1) << p, "R5 single bit B high");
      applyPair(~(W'(1) << p), 24'hFFFFFF, "R5 single bit A low");
    end

    // R6: all-ones against all-zeros, and MSB of difference dominating
    applyPair(24'hFFFFFF, 24'h000000, "R6 ones vs zeros");
    applyPair(24'h000000, 24'hFFFFFF, "R6 zeros vs ones");
    applyPair(24'h080000, 24'h07FFFF, "R6 group boundary 19");
    applyPair(24'h003FFF, 24'h004000, "R6 group boundary 14");
    applyPair(24'h000010, 24'h00000F, "R6 group boundary 4");
    applyPair(24'h000210, 24'h00020F, "R6 low nibble loses");

    // R1, R2, R4: random pairs, some sharing high bits to reach low groups
    for (int i = 0; i < NUM_RANDOM; i++) begin
      logic [W-1:0] ra, rb, mask;
      ra = W'($urandom);
      rb = W'($urandom);
      mask = W'(24'hFFFFFF) << ($urandom % W);
      if (i % 3 == 1) rb = (ra & mask) | (rb & ~mask);
      if (i % 7 == 0) rb = ra;
      applyPair(ra, rb, "R1 R2 R4 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule